// File: doc/BRIEF.md
# Performance Counter Global Control Unit

This block holds a bank of general-purpose event counters (four or eight, set by a parameter) and three fixed-function counters. Each counter advances on its own increment pulse, but only while two gates are open: a bit in one global enable register, and a per-counter local enable chosen by the current privilege level. The privilege level is user or supervisor, and each level has its own local enable register.

When a counter wraps from all ones to zero, a sticky bit is set in a global overflow status register. Software clears these bits through a write-one-to-clear register. A separate external pulse records overflow of a trace buffer in the same status register.

All registers sit behind one simple register port. Writes are registered, and reads are combinational. A write to the global enable register that sets any unimplemented or reserved bit is refused: the register keeps its old value and a fault pulse is raised.

Top module: `pmu_global_ctl`

Register map (5-bit address):
- 0: global enable.
- 1: overflow status, read-only.
- 2: overflow clear, write-one-to-clear.
- 3: user local enables.
- 4: supervisor local enables.
- 8+i: general-purpose counter i.
- 16+j: fixed counter j.

## Requirements
- R1: After reset, every enable register, every counter and every status bit reads 0, and `fault` is low.
- R2: In the global enable register, general-purpose counter i is enabled by bit i, and fixed counters 0, 1 and 2 are enabled by bits 32, 33 and 34. An accepted write reads back exactly, and every other bit position reads 0.
- R3: A write to address 0 with a 1 in any position that R2 does not name (with four counters this includes bits 4 to 7) leaves the register unchanged. It drives `fault` high for exactly the cycle after the write edge.
- R4: A counter adds 1 on each clock edge where its increment input is high, its global enable bit is set, and its local enable bit is set. The local enable bit is taken from address 4 when `priv_sup` is 1, and from address 3 otherwise.
- R5: A counter does not change while either gate is closed. A write that closes a gate takes effect at its own edge, so an increment in that same cycle is still counted.
- R6: When a counter wraps from all ones (48 bits) to zero, its status bit is set at that same edge. The status bit sits at the same position as the counter's enable bit in R2.
- R7: Status bits stay set until a write to address 2 with a 1 in their position. If an overflow and a clear of the same bit meet in one cycle, the bit stays set.
- R8: A high `trace_ovf` at a clock edge sets status bit 62. That bit is sticky and is cleared only as described in R7.
- R9: A write to a counter address loads the counter with the low 48 bits of the write data. A read of that address returns the value zero-extended. Addresses of general-purpose counters that are not implemented read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data |
| fault | output | 1 | One-cycle pulse after a refused global enable write |
| priv_sup | input | 1 | Current privilege level: 1 is supervisor, 0 is user |
| gp_inc | input | NUM_GP | Increment pulses for the general-purpose counters |
| fx_inc | input | 3 | Increment pulses for the fixed counters |
| trace_ovf | input | 1 | Trace buffer overflow pulse |

## Verification
Two pairs of events can land on the same edge. The first pair is a counter overflow and a write-one-to-clear of the same status bit. The bench preloads a counter with all ones, then issues the clear write in the very cycle that the increment pulse wraps the counter. The status bit must remain set afterwards.

The second pair is a write that closes a counter's global gate and an increment pulse arriving with it. That pulse must still be counted, and the next pulse must not be.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   localparam int REG_W    = 64;
   localparam int ADDR_W   = 5;
   localparam int NUM_FIX  = 3;
   localparam int FIX_BASE = 32;
   localparam int TRACE_BIT = 62;

   localparam logic [ADDR_W-1:0] A_GCTL = 5'd0;
   localparam logic [ADDR_W-1:0] A_STAT = 5'd1;
   localparam logic [ADDR_W-1:0] A_OCLR = 5'd2;
   localparam logic [ADDR_W-1:0] A_UEN  = 5'd3;
   localparam logic [ADDR_W-1:0] A_SEN  = 5'd4;
   localparam logic [ADDR_W-1:0] A_GP0  = 5'd8;
   localparam logic [ADDR_W-1:0] A_FX0  = 5'd16;

   function automatic logic [REG_W-1:0] en_mask(input int num_gp);
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < num_gp; i++) m[i] = 1'b1;
      for (int j = 0; j < NUM_FIX; j++) m[FIX_BASE+j] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
   parameter int CNT_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             inc_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);
   logic step;
   assign step  = en_i & inc_i & ~wr_i;
   assign ovf_o = step & (&cnt_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_o <= '0;
      else if (wr_i) cnt_o <= wdata_i;
      else if (step) cnt_o <= cnt_o + 1'b1;
   end

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && inc_i && !wr_i) |=> cnt_o == $past(cnt_o) + 1'b1); // R4
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(en_i && inc_i) && !wr_i) |=> $stable(cnt_o)); // R5
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> cnt_o == '0); // R6
endmodule

// File: rtl/pmu_mask_reg.sv
module pmu_mask_reg #(
   parameter int              W        = 64,
   parameter logic [W-1:0]    MASK     = '1,
   parameter bit              STRICT   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] q_o,
   output logic         fault_o
);
   logic bad;
   assign bad = |(wdata_i & ~MASK);

   generate
      if (STRICT) begin : g_strict
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_o     <= '0;
               fault_o <= 1'b0;
            end else begin
               fault_o <= wr_i & bad;
               if (wr_i && !bad) q_o <= wdata_i;
            end
         end
         AST_REFUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && bad) |=> (fault_o && q_o == $past(q_o))); // R3
      end else begin : g_masked
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q_o <= '0;
            else if (wr_i) q_o <= wdata_i & MASK;
         end
         assign fault_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pmu_global_ctl.sv
module pmu_global_ctl
   import pmu_pkg::*;
#(
   parameter int NUM_GP = 4,
   parameter int CNT_W  = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              fault,
   input  logic              priv_sup,
   input  logic [NUM_GP-1:0] gp_inc,
   input  logic [NUM_FIX-1:0] fx_inc,
   input  logic              trace_ovf
);
   localparam logic [REG_W-1:0] EN_MASK = en_mask(NUM_GP);
   localparam logic [REG_W-1:0] ST_MASK = EN_MASK | (64'd1 << TRACE_BIT);
   localparam int PAD_W = REG_W - CNT_W;

   generate
      if (NUM_GP != 4 && NUM_GP != 8) begin : g_bad_gp
         $error("NUM_GP must be 4 or 8");
      end
      if (CNT_W < 8 || CNT_W > 63) begin : g_bad_w
         $error("CNT_W must lie in 8..63");
      end
   endgenerate

   logic [REG_W-1:0] gctl_q, uen_q, sen_q, lcl_en, gate, stat_q, ovf_vec, clr_vec;
   logic             uen_flt, sen_flt;
   logic             clr_now;
   logic [CNT_W-1:0] gp_cnt [NUM_GP];
   logic [CNT_W-1:0] fx_cnt [NUM_FIX];
   logic [NUM_GP-1:0]  gp_ovf;
   logic [NUM_FIX-1:0] fx_ovf;

   pmu_mask_reg #(.W(REG_W), .MASK(EN_MASK), .STRICT(1'b1)) u_gctl (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_we && reg_addr == A_GCTL),
      .wdata_i(reg_wdata), .q_o(gctl_q), .fault_o(fault));
   pmu_mask_reg #(.W(REG_W), .MASK(EN_MASK), .STRICT(1'b0)) u_uen (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_we && reg_addr == A_UEN),
      .wdata_i(reg_wdata), .q_o(uen_q), .fault_o(uen_flt));
   pmu_mask_reg #(.W(REG_W), .MASK(EN_MASK), .STRICT(1'b0)) u_sen (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_we && reg_addr == A_SEN),
      .wdata_i(reg_wdata), .q_o(sen_q), .fault_o(sen_flt));

   assign lcl_en = priv_sup ? sen_q : uen_q;
   assign gate   = gctl_q & lcl_en;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_GP; gi++) begin : g_gp
         pmu_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .en_i(gate[gi]), .inc_i(gp_inc[gi]),
            .wr_i(reg_we && reg_addr == A_GP0 + ADDR_W'(gi)),
            .wdata_i(reg_wdata[CNT_W-1:0]), .cnt_o(gp_cnt[gi]), .ovf_o(gp_ovf[gi]));
      end
      for (gi = 0; gi < NUM_FIX; gi++) begin : g_fx
         pmu_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .en_i(gate[FIX_BASE+gi]), .inc_i(fx_inc[gi]),
            .wr_i(reg_we && reg_addr == A_FX0 + ADDR_W'(gi)),
            .wdata_i(reg_wdata[CNT_W-1:0]), .cnt_o(fx_cnt[gi]), .ovf_o(fx_ovf[gi]));
      end
   endgenerate

   always_comb begin
      ovf_vec = '0;
      for (int i = 0; i < NUM_GP; i++)  ovf_vec[i] = gp_ovf[i];
      for (int j = 0; j < NUM_FIX; j++) ovf_vec[FIX_BASE+j] = fx_ovf[j];
      ovf_vec[TRACE_BIT] = trace_ovf;
   end

   assign clr_now = reg_we && reg_addr == A_OCLR;
   assign clr_vec = clr_now ? (reg_wdata & ST_MASK) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_vec) | ovf_vec;
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_GCTL:  reg_rdata = gctl_q;
         A_STAT:  reg_rdata = stat_q;
         A_UEN:   reg_rdata = uen_q;
         A_SEN:   reg_rdata = sen_q;
         default: begin
            for (int i = 0; i < NUM_GP; i++)
               if (reg_addr == A_GP0 + ADDR_W'(i)) reg_rdata = {{PAD_W{1'b0}}, gp_cnt[i]};
            for (int j = 0; j < NUM_FIX; j++)
               if (reg_addr == A_FX0 + ADDR_W'(j)) reg_rdata = {{PAD_W{1'b0}}, fx_cnt[j]};
         end
      endcase
   end

   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_now |=> (stat_q & $past(stat_q)) == $past(stat_q)); // R7
   AST_OVF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_vec != '0) |=> (stat_q & $past(ovf_vec)) == $past(ovf_vec)); // R6
   AST_NO_SPARE_FLT: assert property (@(posedge clk) disable iff (!rst_n)
      !(uen_flt || sen_flt)); // R3
   AST_GCTL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      (gctl_q & ~EN_MASK) == '0); // R2
endmodule

// File: tb/sim_pmu_global_ctl.sv
module sim_pmu_global_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        fault;
   logic        priv_sup = 1'b0;
   logic [3:0]  gp_inc = '0;
   logic [2:0]  fx_inc = '0;
   logic        trace_ovf = 1'b0;

   int total = 0;
   int bad = 0;
   logic [63:0] v;
   localparam logic [63:0] ONES48 = 64'hFFFF_FFFF_FFFF;

   always #5 clk = ~clk;

   pmu_global_ctl #(.NUM_GP(4), .CNT_W(48)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fault(fault),
      .priv_sup(priv_sup), .gp_inc(gp_inc), .fx_inc(fx_inc), .trace_ovf(trace_ovf));

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic cyc(input logic we, input logic [4:0] a, input logic [63:0] d,
                      input logic [3:0] gi, input logic [2:0] fi, input logic tr);
      @(negedge clk);
      reg_we = we; reg_addr = a; reg_wdata = d; gp_inc = gi; fx_inc = fi; trace_ovf = tr;
      @(negedge clk);
      reg_we = 1'b0; gp_inc = '0; fx_inc = '0; trace_ovf = 1'b0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [63:0] d);
      cyc(1'b1, a, d, 4'h0, 3'h0, 1'b0);
   endtask

   task automatic rd(input logic [4:0] a, output logic [63:0] q);
      @(negedge clk);
      reg_addr = a;
      #1 q = reg_rdata;
   endtask

   task automatic t_reset;
      rd(5'd0, v);  chk("R1 ctrl", v, 64'h0);
      rd(5'd1, v);  chk("R1 status", v, 64'h0);
      rd(5'd8, v);  chk("R1 counter", v, 64'h0);
      chk("R1 fault", {63'h0, fault}, 64'h0);
   endtask

   task automatic t_ctrl;
      wr(5'd0, 64'h7_0000_000F);
      chk("R2 fault low", {63'h0, fault}, 64'h0);
      rd(5'd0, v);  chk("R2 readback", v, 64'h7_0000_000F);
      wr(5'd0, 64'h10);
      chk("R3 fault bit4", {63'h0, fault}, 64'h1);
      rd(5'd0, v);  chk("R3 hold bit4", v, 64'h7_0000_000F);
      chk("R3 fault one cycle", {63'h0, fault}, 64'h0);
      wr(5'd0, 64'h100_0000_0001);
      chk("R3 fault bit40", {63'h0, fault}, 64'h1);
      rd(5'd0, v);  chk("R3 hold bit40", v, 64'h7_0000_000F);
      wr(5'd0, 64'h0);
   endtask

   task automatic t_count;
      wr(5'd3, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(5'd3, v);  chk("R2 local mask reserved zero", v, 64'h7_0000_000F);
      wr(5'd0, 64'h1);
      for (int k = 0; k < 5; k++) cyc(1'b0, 5'd0, 64'h0, 4'h1, 3'h0, 1'b0);
      rd(5'd8, v);  chk("R4 five counts", v, 64'd5);
      cyc(1'b0, 5'd0, 64'h0, 4'h2, 3'h0, 1'b0);
      rd(5'd9, v);  chk("R5 gp1 global off", v, 64'd0);
      priv_sup = 1'b1;
      cyc(1'b0, 5'd0, 64'h0, 4'h1, 3'h0, 1'b0);
      rd(5'd8, v);  chk("R4 supervisor mask closed", v, 64'd5);
      wr(5'd4, 64'h1);
      cyc(1'b0, 5'd0, 64'h0, 4'h1, 3'h0, 1'b0);
      rd(5'd8, v);  chk("R4 supervisor mask open", v, 64'd6);
      cyc(1'b1, 5'd0, 64'h0, 4'h1, 3'h0, 1'b0);
      rd(5'd8, v);  chk("R5 inc with disabling write counted", v, 64'd7);
      cyc(1'b0, 5'd0, 64'h0, 4'h1, 3'h0, 1'b0);
      rd(5'd8, v);  chk("R5 stopped after disable", v, 64'd7);
      priv_sup = 1'b0;
   endtask

   task automatic t_wrap;
      wr(5'd9, ONES48 - 1);
      rd(5'd9, v);  chk("R9 counter load", v, ONES48 - 1);
      wr(5'd12, 64'h55);
      rd(5'd12, v); chk("R9 missing counter reads 0", v, 64'h0);
      wr(5'd0, 64'h4_0000_0002);
      cyc(1'b0, 5'd0, 64'h0, 4'h2, 3'h0, 1'b0);
      rd(5'd9, v);  chk("R6 at all ones", v, ONES48);
      rd(5'd1, v);  chk("R6 no status yet", v, 64'h0);
      cyc(1'b0, 5'd0, 64'h0, 4'h2, 3'h0, 1'b0);
      rd(5'd9, v);  chk("R6 wrapped to zero", v, 64'h0);
      rd(5'd1, v);  chk("R6 status gp1", v, 64'h2);
      wr(5'd18, ONES48);
      cyc(1'b0, 5'd0, 64'h0, 4'h0, 3'h4, 1'b0);
      rd(5'd18, v); chk("R6 fixed2 wrapped", v, 64'h0);
      rd(5'd1, v);  chk("R6 status fixed2 bit34", v, 64'h4_0000_0002);
   endtask

   task automatic t_sticky;
      cyc(1'b0, 5'd0, 64'h0, 4'h0, 3'h0, 1'b0);
      rd(5'd1, v);  chk("R7 sticky", v, 64'h4_0000_0002);
      wr(5'd2, 64'h2);
      rd(5'd1, v);  chk("R7 clear one bit", v, 64'h4_0000_0000);
      wr(5'd9, ONES48);
      cyc(1'b1, 5'd2, 64'h4_0000_0002, 4'h2, 3'h0, 1'b0);
      rd(5'd1, v);  chk("R7 overflow wins over clear", v, 64'h2);
      wr(5'd2, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(5'd1, v);  chk("R7 clear all", v, 64'h0);
   endtask

   task automatic t_trace;
      cyc(1'b0, 5'd0, 64'h0, 4'h0, 3'h0, 1'b1);
      rd(5'd1, v);  chk("R8 trace bit62 set", v, 64'h4000_0000_0000_0000);
      cyc(1'b0, 5'd0, 64'h0, 4'h0, 3'h0, 1'b0);
      rd(5'd1, v);  chk("R8 trace sticky", v, 64'h4000_0000_0000_0000);
      wr(5'd2, 64'h4000_0000_0000_0000);
      rd(5'd1, v);  chk("R8 trace cleared", v, 64'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_ctrl;
      t_count;
      t_wrap;
      t_sticky;
      t_trace;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule